// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of already-synchronized general-purpose input levels and raises interrupts from them. Each pin has its own configuration: a 3-bit trigger selector, four destination enables, a wake enable and an output-style bit. On every clock the block checks whether the pin's chosen condition holds. The condition is a rising edge, a falling edge, either edge, a low level or a high level. When it holds, the block latches a pending bit for that pin, and the bit stays set until software pulses the matching write-one-to-clear strobe.

Pending bits are merged into four interrupt lines: one maskable and one non-maskable line for each of two processors. Each pin chooses its lines through its destination enables. A wake request is raised while the system reports light sleep and a wake-enabled pin has a pending bit. Each pin also has an output-style stage that turns a core data/enable pair into pad controls, either push-pull or open-drain.

Top module: `pin_irq_router`

## Requirements
- R1: A trigger selector of 0, 6 or 7 never sets a pin's pending bit.
- R2: Selector 1 sets the pending bit in the clock in which the sampled level goes from 0 to 1.
- R3: Selector 2 sets the pending bit on a 1-to-0 transition. Selector 3 sets it on either transition.
- R4: Selector 4 sets the pending bit in every clock where the level is 0, and selector 5 in every clock where it is 1. If the level still holds when a clear arrives, the bit is set again in that same clock.
- R5: A pending bit stays set until its clear strobe is high at a clock edge. If a clear and a new trigger event fall in the same clock, the bit stays set.
- R6: Destination enable bit 0 routes a pin to `irq_cpu1` and bit 1 to `nmi_cpu1`. Bit 2 routes it to `irq_cpu0` and bit 3 to `nmi_cpu0`. Each line is the OR over all pins of pending AND enable.
- R7: `wake_req` is high only while `light_sleep` is high and at least one wake-enabled pin has its pending bit set.
- R8: When the output-style bit is 0, the pad enable and pad data follow the core enable and data. When it is 1, the pad data is 0 and the pad enable is the core enable with the core data inverted, so a driven 1 releases the pad.
- R9: While reset is low, all pending bits and all interrupt and wake outputs are 0. The remembered previous level is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NPINS | Synchronized pin input levels |
| cfg_trig | input | 3*NPINS | Trigger selector, pin i at bits [3i+2:3i] |
| cfg_dest | input | 4*NPINS | Destination enables, pin i at bits [4i+3:4i] |
| cfg_wake | input | NPINS | Per-pin wake enable |
| cfg_odrain | input | NPINS | Per-pin output style, 1 = open-drain |
| clr_pend | input | NPINS | Write-one-to-clear strobes |
| light_sleep | input | 1 | System is in light sleep |
| core_do | input | NPINS | Core output data per pin |
| core_oe | input | NPINS | Core output enable per pin |
| pend | output | NPINS | Latched pending bits |
| irq_cpu0 | output | 1 | First processor, maskable |
| nmi_cpu0 | output | 1 | First processor, non-maskable |
| irq_cpu1 | output | 1 | Second processor, maskable |
| nmi_cpu1 | output | 1 | Second processor, non-maskable |
| wake_req | output | 1 | Light-sleep wake request |
| pad_do | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enable |

## Verification
A clear strobe and a fresh trigger event can land on the same pin in the same clock. The bench provokes this in two ways. On an edge pin it raises the level in the same cycle as the clear. On a level pin it clears while the level still holds. A reference model in the bench predicts that the pending bit survives in both cases, and a scoreboard compares that prediction with the pending vector, the four lines and the wake request one edge later.

// File: rtl/pin_irq_pkg.sv
// Package: shared constants for the per-pin interrupt detector.
// Assumes callers use 3-bit trigger selectors and 4-bit destination masks.
package pin_irq_pkg;
    localparam int TRIG_W = 3;
    localparam int DEST_W = 4;

    localparam logic [TRIG_W-1:0] TRIG_OFF  = 3'd0;
    localparam logic [TRIG_W-1:0] TRIG_RISE = 3'd1;
    localparam logic [TRIG_W-1:0] TRIG_FALL = 3'd2;
    localparam logic [TRIG_W-1:0] TRIG_BOTH = 3'd3;
    localparam logic [TRIG_W-1:0] TRIG_LOW  = 3'd4;
    localparam logic [TRIG_W-1:0] TRIG_HIGH = 3'd5;

    localparam int DST_CPU1_IRQ = 0;
    localparam int DST_CPU1_NMI = 1;
    localparam int DST_CPU0_IRQ = 2;
    localparam int DST_CPU0_NMI = 3;
endpackage

// File: rtl/pin_trig_detect.sv
// Module: one pin's trigger detector and sticky pending bit.
// Assumes level is already synchronized. Selectors 0, 6 and 7 detect nothing.
// A hit in the same clock as a clear leaves the bit set.
module pin_trig_detect
    import pin_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic [TRIG_W-1:0] trig,
    input  logic              clr,
    output logic              pend
);
    logic prev_q;
    logic hit;

    // Decode the selector into a trigger event for this clock.
    always_comb begin
        case (trig)
            TRIG_RISE: hit = level & ~prev_q;
            TRIG_FALL: hit = ~level & prev_q;
            TRIG_BOTH: hit = level ^ prev_q;
            TRIG_LOW:  hit = ~level;
            TRIG_HIGH: hit = level;
            default:   hit = 1'b0;
        endcase
    end

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Sticky pending bit: clear first, then a new hit sets it again.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend & ~clr) | hit;
    end
endmodule

// File: rtl/irq_fanout.sv
// Module: merges pending bits into four processor lines and a wake request.
// Assumes dest is packed DEST_W bits per pin and every output is combinational.
module irq_fanout
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 40
) (
    input  logic [NPINS-1:0]        pend,
    input  logic [NPINS*DEST_W-1:0] dest,
    input  logic [NPINS-1:0]        wake_en,
    input  logic                    light_sleep,
    output logic [DEST_W-1:0]       lines,
    output logic                    wake_req
);
    genvar d, p;
    generate
        for (d = 0; d < DEST_W; d++) begin : g_dst
            logic [NPINS-1:0] col;
            for (p = 0; p < NPINS; p++) begin : g_pin
                assign col[p] = dest[p*DEST_W + d];
            end
            // OR of pending AND enable across every pin for this destination.
            assign lines[d] = |(pend & col);
        end
    endgenerate

    // Wake only in light sleep and only from a wake-enabled pending pin.
    assign wake_req = light_sleep & (|(pend & wake_en));
endmodule

// File: rtl/pad_drive_ctl.sv
// Module: per-pin output-style stage, push-pull or open-drain.
// Assumes core data and enable come straight from the output path.
module pad_drive_ctl #(
    parameter int NPINS = 40
) (
    input  logic [NPINS-1:0] odrain,
    input  logic [NPINS-1:0] core_do,
    input  logic [NPINS-1:0] core_oe,
    output logic [NPINS-1:0] pad_do,
    output logic [NPINS-1:0] pad_oe
);
    // Open-drain only ever drives low and releases the pad on a 1.
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (odrain[i]) begin
                pad_do[i] = 1'b0;
                pad_oe[i] = core_oe[i] & ~core_do[i];
            end else begin
                pad_do[i] = core_do[i];
                pad_oe[i] = core_oe[i];
            end
        end
    end
endmodule

// File: rtl/pin_irq_router.sv
// Module: top of the per-pin interrupt detector.
// Assumes synchronized inputs and configuration held stable by software.
module pin_irq_router
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        pin_level,
    input  logic [NPINS*TRIG_W-1:0] cfg_trig,
    input  logic [NPINS*DEST_W-1:0] cfg_dest,
    input  logic [NPINS-1:0]        cfg_wake,
    input  logic [NPINS-1:0]        cfg_odrain,
    input  logic [NPINS-1:0]        clr_pend,
    input  logic                    light_sleep,
    input  logic [NPINS-1:0]        core_do,
    input  logic [NPINS-1:0]        core_oe,
    output logic [NPINS-1:0]        pend,
    output logic                    irq_cpu0,
    output logic                    nmi_cpu0,
    output logic                    irq_cpu1,
    output logic                    nmi_cpu1,
    output logic                    wake_req,
    output logic [NPINS-1:0]        pad_do,
    output logic [NPINS-1:0]        pad_oe
);
    logic [DEST_W-1:0] lines;

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_det
            pin_trig_detect u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .level (pin_level[i]),
                .trig  (cfg_trig[i*TRIG_W +: TRIG_W]),
                .clr   (clr_pend[i]),
                .pend  (pend[i])
            );
        end
    endgenerate

    irq_fanout #(.NPINS(NPINS)) u_fan (
        .pend        (pend),
        .dest        (cfg_dest),
        .wake_en     (cfg_wake),
        .light_sleep (light_sleep),
        .lines       (lines),
        .wake_req    (wake_req)
    );

    assign irq_cpu1 = lines[DST_CPU1_IRQ];
    assign nmi_cpu1 = lines[DST_CPU1_NMI];
    assign irq_cpu0 = lines[DST_CPU0_IRQ];
    assign nmi_cpu0 = lines[DST_CPU0_NMI];

    pad_drive_ctl #(.NPINS(NPINS)) u_pad (
        .odrain  (cfg_odrain),
        .core_do (core_do),
        .core_oe (core_oe),
        .pad_do  (pad_do),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/pin_irq_router_chk.sv
// Checker: temporal properties of the detector, bound to the top module.
module pin_irq_router_chk
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 40
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPINS-1:0]        pin_level,
    input logic [NPINS*TRIG_W-1:0] cfg_trig,
    input logic [NPINS*DEST_W-1:0] cfg_dest,
    input logic [NPINS-1:0]        cfg_wake,
    input logic [NPINS-1:0]        cfg_odrain,
    input logic [NPINS-1:0]        clr_pend,
    input logic                    light_sleep,
    input logic [NPINS-1:0]        core_do,
    input logic [NPINS-1:0]        core_oe,
    input logic [NPINS-1:0]        pend,
    input logic                    irq_cpu0,
    input logic                    nmi_cpu0,
    input logic                    irq_cpu1,
    input logic                    nmi_cpu1,
    input logic                    wake_req,
    input logic [NPINS-1:0]        pad_do,
    input logic [NPINS-1:0]        pad_oe
);
    logic [NPINS-1:0] nmi0_mask;
    logic [NPINS-1:0] off_sel;

    // Gather per-pin masks used by the properties.
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            nmi0_mask[i] = cfg_dest[i*DEST_W + DST_CPU0_NMI];
            off_sel[i]   = (cfg_trig[i*TRIG_W +: TRIG_W] == TRIG_OFF) ||
                           (cfg_trig[i*TRIG_W +: TRIG_W] > TRIG_HIGH);
        end
    end

    // R7: no wake outside light sleep.
    a_r7_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        !light_sleep |-> !wake_req);

    // R6: the first processor's non-maskable line needs an enabled pending pin.
    a_r6_nmi0_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_cpu0 |-> |(pend & nmi0_mask));

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_chk
            // R1: a disabled selector never raises a clear pending bit.
            a_r1_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(off_sel[g]) && !$past(pend[g])) |-> !pend[g]);
            // R5: pending holds until cleared.
            a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(pend[g]) && !$past(clr_pend[g])) |-> pend[g]);
            // R8: open-drain releases on a driven 1 and never drives high.
            a_r8_od_release: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_odrain[g] && core_do[g]) |-> (!pad_oe[g] && !pad_do[g]));
        end
    endgenerate
endmodule

bind pin_irq_router pin_irq_router_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/pin_irq_router_test.sv
// Scoreboard bench: the driver predicts, the monitor compares one edge later.
module pin_irq_router_test;
    localparam int N = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   pin_level = '0;
    logic [N*3-1:0] cfg_trig = '0;
    logic [N*4-1:0] cfg_dest = '0;
    logic [N-1:0]   cfg_wake = '0;
    logic [N-1:0]   cfg_odrain = '0;
    logic [N-1:0]   clr_pend = '0;
    logic           light_sleep = 1'b0;
    logic [N-1:0]   core_do = '0;
    logic [N-1:0]   core_oe = '0;
    logic [N-1:0]   pend;
    logic irq_cpu0, nmi_cpu0, irq_cpu1, nmi_cpu1, wake_req;
    logic [N-1:0]   pad_do, pad_oe;

    pin_irq_router #(.NPINS(N)) uut (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        logic [N-1:0] st;
        logic [3:0]   ln;
        logic         wk;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [N-1:0] m_prev = '0;
    logic [N-1:0] m_st = '0;

    // Lines packed by destination bit: 0 cpu1 irq, 1 cpu1 nmi, 2 cpu0 irq, 3 cpu0 nmi.
    function automatic logic [3:0] out_lines();
        return {nmi_cpu0, irq_cpu0, nmi_cpu1, irq_cpu1};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus at a negedge and pushes the prediction.
    task automatic step(input logic [N-1:0] lv, input logic [N-1:0] clr,
                        input logic ls, input string tag);
        exp_t e;
        logic [N-1:0] hit;
        logic [3:0] ln;
        pin_level   = lv;
        clr_pend    = clr;
        light_sleep = ls;
        for (int i = 0; i < N; i++) begin
            case (cfg_trig[i*3 +: 3])
                3'd1:    hit[i] = lv[i] & ~m_prev[i];
                3'd2:    hit[i] = ~lv[i] & m_prev[i];
                3'd3:    hit[i] = lv[i] ^ m_prev[i];
                3'd4:    hit[i] = ~lv[i];
                3'd5:    hit[i] = lv[i];
                default: hit[i] = 1'b0;
            endcase
        end
        m_st   = (m_st & ~clr) | hit;
        m_prev = lv;
        ln = '0;
        for (int i = 0; i < N; i++)
            for (int d = 0; d < 4; d++)
                if (m_st[i] && cfg_dest[i*4 + d]) ln[d] = 1'b1;
        e.st  = m_st;
        e.ln  = ln;
        e.wk  = ls && ((m_st & cfg_wake) != '0);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: just after each edge, pops the oldest prediction and compares.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (pend !== e.st || out_lines() !== e.ln || wake_req !== e.wk) begin
                    n_fail++;
                    $display("FAIL %s: pend=%h lines=%b wake=%b expected pend=%h lines=%b wake=%b",
                             e.tag, pend, out_lines(), wake_req, e.st, e.ln, e.wk);
                end
            end
        end
    end

    task automatic pad_check(input logic od, input logic d, input logic oe,
                             input logic exp_do, input logic exp_oe);
        cfg_odrain[7] = od;
        core_do[7]    = d;
        core_oe[7]    = oe;
        #1;
        n_tests++;
        if (pad_do[7] !== exp_do || pad_oe[7] !== exp_oe) begin
            n_fail++;
            $display("FAIL R8: pad_do=%b pad_oe=%b expected %b %b",
                     pad_do[7], pad_oe[7], exp_do, exp_oe);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] lv;
        logic [N-1:0] z;
        z = '0;
        // Pin setup: 0 rise, 1 fall, 2 both, 3 low, 4 high, 5 off, 6 sel7, 39 rise.
        cfg_trig[0*3 +: 3]  = 3'd1; cfg_dest[0*4 +: 4]  = 4'b0100; cfg_wake[0] = 1'b1;
        cfg_trig[1*3 +: 3]  = 3'd2; cfg_dest[1*4 +: 4]  = 4'b0001;
        cfg_trig[2*3 +: 3]  = 3'd3; cfg_dest[2*4 +: 4]  = 4'b1000;
        cfg_trig[3*3 +: 3]  = 3'd4; cfg_dest[3*4 +: 4]  = 4'b0010;
        cfg_trig[4*3 +: 3]  = 3'd5; cfg_dest[4*4 +: 4]  = 4'b0000;
        cfg_trig[5*3 +: 3]  = 3'd0; cfg_dest[5*4 +: 4]  = 4'b1111;
        cfg_trig[6*3 +: 3]  = 3'd7; cfg_dest[6*4 +: 4]  = 4'b1111; cfg_wake[6] = 1'b1;
        cfg_trig[39*3 +: 3] = 3'd1; cfg_dest[39*4 +: 4] = 4'b1001; cfg_wake[39] = 1'b1;
        lv = '0;
        lv[1] = 1'b1;
        pin_level = lv;
        repeat (3) @(negedge clk);
        // R9: reset state, with a low-level pin already low.
        n_tests++;
        if (pend !== '0 || out_lines() !== 4'b0 || wake_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: pend=%h lines=%b wake=%b expected 0 0 0", pend, out_lines(), wake_req);
        end
        rst_n = 1'b1;

        step(lv, z, 1'b0, "R4 low level sets");
        step(lv, 40'h8, 1'b0, "R4 clear while low re-latches");
        lv[3] = 1'b1;
        step(lv, z, 1'b0, "R4 level gone, still sticky");
        step(lv, 40'h8, 1'b0, "R5 clear without event");
        lv[0] = 1'b1;
        step(lv, z, 1'b0, "R2 rising edge sets");
        step(lv, z, 1'b1, "R7 wake in light sleep");
        step(lv, 40'h1, 1'b1, "R7 clear drops wake");
        lv[0] = 1'b0;
        step(lv, z, 1'b1, "R2 falling ignored by rise");
        lv[1] = 1'b0;
        step(lv, z, 1'b0, "R3 falling edge sets");
        lv[2] = 1'b1;
        step(lv, 40'h2, 1'b0, "R3 both-edge rise");
        step(lv, 40'h4, 1'b0, "R3 clear both-edge");
        lv[2] = 1'b0;
        step(lv, z, 1'b0, "R3 both-edge fall");
        lv[4] = 1'b1;
        step(lv, 40'h4, 1'b0, "R4 high level sets");
        lv[5] = 1'b1; lv[6] = 1'b1;
        step(lv, 40'h10, 1'b1, "R1 disabled selectors rise");
        lv[5] = 1'b0; lv[6] = 1'b0;
        step(lv, z, 1'b1, "R1 disabled selectors fall");
        lv[39] = 1'b1;
        step(lv, z, 1'b1, "R6 pin 39 to cpu0 nmi and cpu1 irq");
        lv[39] = 1'b0;
        step(lv, z, 1'b0, "R6 pin 39 sticky, no wake awake");
        lv[39] = 1'b1;
        step(lv, {1'b1, 39'b0}, 1'b1, "R5 clear and new edge same cycle");
        step(lv, {1'b1, 39'b0}, 1'b0, "R5 clear without event");
        step(lv, z, 1'b0, "R5 idle after clear");
        @(negedge clk);

        pad_check(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        pad_check(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        pad_check(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        pad_check(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        pad_check(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule